// File: doc/BRIEF.md
# Packet Function Dispatch Controller

This block steers the packets that reach one functional unit. Each packet starts with a four-word header: base, source, function code, and then the number of data samples that follow. The controller stores the header and decodes the function code. It then chooses exactly one of the unit's functional elements and sends the packet's samples through that element alone. Every element is wired to the unit's input and output ports at build time. Only the dispatch chooses which element sees the traffic.

The unit has four elements, and each one has a pipeline of `LAT` register stages. They are a pass-through, an add of a constant, a two's-complement negate, and a running sum that keeps its total from one sample to the next and starts again from zero at every new packet. A valid packet goes out as its header, unchanged, followed by the processed samples. A packet with an unknown function code raises an error pulse. Its samples are then taken in and thrown away, and nothing appears on the output.

Both ports use valid/ready handshakes and take full backpressure. The controller does not open the next packet until the element in use has delivered every result still in its pipeline. This keeps the active element unique and keeps the packets in order.

Top module: `fu_dispatch_ctrl`

## Requirements
- R1: Input header words are taken in the order base, source, function code, length, and `in_ready` is high while a header is being collected. The length word gives the number of data samples that follow.
- R2: Function codes 0, 1, 2 and 3 select pass-through, add `ADD_K` modulo 2^DW, two's-complement negate, and running sum. For the running sum, output sample k is the sum modulo 2^DW of input samples 0..k of the same packet.
- R3: At most one functional element holds or takes data at any time, and each packet's samples are handled only by the element its function code selects.
- R4: For a valid function code, the four header words are sent on the output unchanged and in input order, ahead of the packet's results.
- R5: A function code of 4 or more drives `func_err` high for exactly one cycle, starting the cycle after the fourth header word is accepted. That packet's data samples are accepted and dropped, and no output word is produced for the packet.
- R6: A valid packet with length 0 produces only its four header words, and the next packet is taken after it.
- R7: After the last sample of a packet is accepted, `in_ready` stays low until every result of that packet has left the output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays constant. No word is lost or duplicated under backpressure.
- R9: During and right after reset, `out_valid` and `func_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DW | Input header or data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | DW | Forwarded header word or processed sample |
| func_err | output | 1 | One-cycle pulse for an unknown function code |

## Verification
The bench builds the block with DW=12, LAT=3 and ADD_K=37. The narrow sample width lets random and directed data reach the modulo wrap of the adder, the negate and the running sum. The three-stage pipeline can hold a whole three-sample packet while the output is stalled. With that, the bench can check that the next header is refused until the pipeline empties. Random packet lengths from 0 to 8, together with codes 4 and 5, cover empty packets and dropped packets between back-to-back function switches.

// File: rtl/fu_pkg.sv
package fu_pkg;

  localparam int FE_COUNT = 4;

  typedef enum logic [1:0] {
    FK_PASS = 2'd0,
    FK_ADDK = 2'd1,
    FK_NEG  = 2'd2,
    FK_ACC  = 2'd3
  } fe_kind_e;

  typedef enum logic [2:0] {
    ST_HDR   = 3'd0,
    ST_OHDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_FLUSH = 3'd3,
    ST_DRAIN = 3'd4
  } ctl_st_e;

endpackage

// File: rtl/fu_hdr_store.sv
module fu_hdr_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] func_word
);
  localparam int NW = 4;

  logic [DW-1:0] words [NW];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  assign rd_data   = words[rd_idx];
  assign func_word = words[2];
endmodule

// File: rtl/fu_elem.sv
module fu_elem
  import fu_pkg::*;
#(
  parameter int       DW    = 16,
  parameter int       LAT   = 2,
  parameter fe_kind_e KIND  = FK_PASS,
  parameter int       ADD_K = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          busy
);
  logic [LAT-1:0] v;
  logic [DW-1:0]  d [LAT];
  logic [DW-1:0]  acc;
  logic           adv;

  function automatic logic [DW-1:0] op_result(input logic [DW-1:0] x,
                                              input logic [DW-1:0] a);
    case (KIND)
      FK_PASS: op_result = x;
      FK_ADDK: op_result = x + DW'(ADD_K);
      FK_NEG:  op_result = '0 - x;
      default: op_result = a + x;
    endcase
  endfunction

  assign adv       = !v[LAT-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = v[LAT-1];
  assign out_data  = d[LAT-1];
  assign busy      = |v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v   <= '0;
      acc <= '0;
    end else begin
      if (start) acc <= '0;
      else if (adv && in_valid) acc <= acc + in_data;
      if (adv) begin
        v[0] <= in_valid;
        for (int s = LAT - 1; s > 0; s--) v[s] <= v[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      d[0] <= op_result(in_data, acc);
      for (int s = LAT - 1; s > 0; s--) d[s] <= d[s-1];
    end
  end

  // R8: a stalled result holds still
  p_elem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/fu_dispatch_ctrl.sv
module fu_dispatch_ctrl
  import fu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LAT   = 2,
  parameter int ADD_K = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          func_err
);
  localparam int SW = $clog2(FE_COUNT);

  ctl_st_e        st;
  logic [1:0]     hcnt, ocnt;
  logic [DW-1:0]  rem;
  logic [SW-1:0]  sel;
  logic [DW-1:0]  hdr_rd, func_word;
  logic           in_fire, hdr_done, func_ok, start;

  logic [FE_COUNT-1:0] e_in_valid, e_in_ready, e_out_valid, e_out_ready;
  logic [FE_COUNT-1:0] e_busy, e_start, act_vec;
  logic [DW-1:0]       e_out_data [FE_COUNT];

  assign in_fire  = in_valid && in_ready;
  assign hdr_done = (st == ST_HDR) && in_valid && (hcnt == 2'd3);
  assign func_ok  = func_word < DW'(FE_COUNT);
  assign start    = (st == ST_OHDR) && out_ready && (ocnt == 2'd3);

  fu_hdr_store #(.DW(DW)) u_hdr (
    .clk      (clk),
    .wr_en    ((st == ST_HDR) && in_valid),
    .wr_idx   (hcnt),
    .wr_data  (in_data),
    .rd_idx   (ocnt),
    .rd_data  (hdr_rd),
    .func_word(func_word)
  );

  for (genvar i = 0; i < FE_COUNT; i++) begin : g_fe
    assign e_in_valid[i]  = in_valid && (st == ST_DATA) && (sel == SW'(i));
    assign e_out_ready[i] = out_ready && (sel == SW'(i)) &&
                            ((st == ST_DATA) || (st == ST_FLUSH));
    assign e_start[i]     = start && (sel == SW'(i));
    assign act_vec[i]     = e_busy[i] || ((st == ST_DATA) && (sel == SW'(i)));

    fu_elem #(.DW(DW), .LAT(LAT), .KIND(fe_kind_e'(i)), .ADD_K(ADD_K)) u_fe (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (e_start[i]),
      .in_valid (e_in_valid[i]),
      .in_ready (e_in_ready[i]),
      .in_data  (in_data),
      .out_valid(e_out_valid[i]),
      .out_ready(e_out_ready[i]),
      .out_data (e_out_data[i]),
      .busy     (e_busy[i])
    );
  end

  always_comb begin
    case (st)
      ST_HDR, ST_DRAIN: in_ready = 1'b1;
      ST_DATA:          in_ready = e_in_ready[sel];
      default:          in_ready = 1'b0;
    endcase
    case (st)
      ST_OHDR:          out_valid = 1'b1;
      ST_DATA, ST_FLUSH: out_valid = e_out_valid[sel];
      default:          out_valid = 1'b0;
    endcase
    out_data = (st == ST_OHDR) ? hdr_rd : e_out_data[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR;
      hcnt     <= '0;
      ocnt     <= '0;
      rem      <= '0;
      sel      <= '0;
      func_err <= 1'b0;
    end else begin
      func_err <= hdr_done && !func_ok;
      case (st)
        ST_HDR: if (in_fire) begin
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3) begin
            rem  <= in_data;
            sel  <= func_word[SW-1:0];
            ocnt <= '0;
            if (func_ok)              st <= ST_OHDR;
            else if (in_data != '0)   st <= ST_DRAIN;
          end
        end
        ST_OHDR: if (out_ready) begin
          ocnt <= ocnt + 2'd1;
          if (ocnt == 2'd3) st <= (rem == '0) ? ST_HDR : ST_DATA;
        end
        ST_DATA: if (in_fire) begin
          rem <= rem - 1'b1;
          if (rem == DW'(1)) st <= ST_FLUSH;
        end
        ST_FLUSH: if (!e_busy[sel]) st <= ST_HDR;
        ST_DRAIN: if (in_fire) begin
          rem <= rem - 1'b1;
          if (rem == DW'(1)) st <= ST_HDR;
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  // R3: never more than one element engaged
  p_one_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec));
  // R7: a new element starts only when every pipeline is empty
  p_start_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (e_busy == '0));
  // R5: dropped packet stays off the output; error is a single pulse
  p_drain_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN) |-> !out_valid);
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    func_err |=> !func_err);
  // R1: header collection always accepts
  p_hdr_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> in_ready);
  // R8: output held under backpressure
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/tb_fu_dispatch_ctrl.sv
module tb_fu_dispatch_ctrl;
  localparam int DW    = 12;
  localparam int LAT   = 3;
  localparam int ADD_K = 37;
  localparam int MASK  = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, func_err;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0, cyc = 0;
  int exp_err = 0, got_err = 0;
  int rdy_mode = 0;
  bit finished = 1'b0;
  bit prev_stall = 1'b0;
  logic [DW-1:0] prev_data;
  int exp_q[$];
  string tag_q[$];
  int pdata[$];

  fu_dispatch_ctrl #(.DW(DW), .LAT(LAT), .ADD_K(ADD_K)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .func_err(func_err));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int f, input int x, inout int acc);
    case (f)
      0: return x;
      1: return (x + ADD_K) & MASK;
      2: return (0 - x) & MASK;
      default: begin
        acc = (acc + x) & MASK;
        return acc;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit rdy;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8 stalled word held",
            int'(out_data), int'(prev_data));
      rdy = (rdy_mode == 1) ? 1'b0 : (rdy_mode == 2) ? 1'b1 : ($urandom % 3 != 0);
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected output word", int'(out_data), -1);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(out_data) == e, t, int'(out_data), e);
        end
      end
      prev_stall = out_valid && !rdy;
      prev_data  = out_data;
      if (func_err) got_err++;
    end
  end

  task automatic send_word(input int w, input bit gaps);
    if (gaps) repeat ($urandom % 3) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(w);
    forever begin
      #2;
      if (in_ready) begin
        @(posedge clk);
        #1 in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(input int f, input bit gaps, input string htag);
    int acc = 0;
    int len = pdata.size();
    int b = $urandom & MASK, s = $urandom & MASK;
    if (f < 4) begin
      exp_q.push_back(b);   tag_q.push_back({htag, " header base"});
      exp_q.push_back(s);   tag_q.push_back({htag, " header source"});
      exp_q.push_back(f);   tag_q.push_back({htag, " header function"});
      exp_q.push_back(len); tag_q.push_back({htag, " header length"});
      foreach (pdata[k]) begin
        exp_q.push_back(model(f, pdata[k], acc));
        tag_q.push_back($sformatf("R2 R3 data f=%0d", f));
      end
    end else exp_err++;
    send_word(b, gaps);
    send_word(s, gaps);
    send_word(f, gaps);
    send_word(len, gaps);
    if (f >= 4) chk(func_err == 1'b1, "R5 error pulse after header", func_err, 1);
    foreach (pdata[k]) send_word(pdata[k], gaps);
  endtask

  task automatic wait_empty();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (LAT + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected words delivered", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && func_err == 1'b0, "R9 outputs low in reset",
        {out_valid, func_err}, 0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 idle after reset",
        {in_ready, out_valid}, 2);

    pdata = '{1, 2, 3};              send_pkt(0, 1, "R1 R4"); wait_empty();
    pdata = '{MASK - 10, MASK, 0, 7}; send_pkt(1, 1, "R1 R4"); wait_empty();
    pdata = '{0, 1, MASK, 2048};     send_pkt(2, 0, "R1 R4"); wait_empty();
    pdata = '{4000, 100, 5, 1, MASK}; send_pkt(3, 1, "R1 R4"); wait_empty();
    pdata = '{};                     send_pkt(2, 0, "R6");    wait_empty();
    pdata = '{9, 8, 7};              send_pkt(7, 1, "R5");    wait_empty();
    pdata = '{};                     send_pkt(4, 0, "R5");    wait_empty();
    pdata = '{10, 20};               send_pkt(3, 0, "R1 R4"); wait_empty();

    rdy_mode = 2;
    pdata = '{};
    send_word(11, 0); send_word(22, 0); send_word(1, 0); send_word(LAT, 0);
    exp_q.push_back(11);  tag_q.push_back("R4 header base");
    exp_q.push_back(22);  tag_q.push_back("R4 header source");
    exp_q.push_back(1);   tag_q.push_back("R4 header function");
    exp_q.push_back(LAT); tag_q.push_back("R4 header length");
    repeat (8) @(negedge clk);
    rdy_mode = 1;
    for (int k = 0; k < LAT; k++) begin
      send_word(100 + k, 0);
      exp_q.push_back((100 + k + ADD_K) & MASK);
      tag_q.push_back("R7 R2 data after stall");
    end
    repeat (6) @(negedge clk);
    #2;
    chk(in_ready == 1'b0, "R7 next header refused while results pending", in_ready, 0);
    chk(out_valid == 1'b1, "R8 result waits under backpressure", out_valid, 1);
    rdy_mode = 0;
    wait_empty();

    for (int p = 0; p < 40; p++) begin
      int len = $urandom % 9;
      pdata = '{};
      for (int k = 0; k < len; k++) pdata.push_back($urandom & MASK);
      send_pkt($urandom % 6, 1, (len == 0) ? "R6" : "R1 R4");
    end
    wait_empty();
    chk(got_err == exp_err, "R5 error pulse count", got_err, exp_err);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule